// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block produces the instruction fetch address for a small accumulator-based 8-bit controller with a 10-bit program space. Each instruction cycle is split into four phases, T1 to T4. A phase counter steps forward only on clocks where the cycle enable is high. All address updates happen together at the single boundary where T4 hands over to T1, which is the moment the next fetch starts.

At that boundary the sequencer takes one of two paths. It either steps to the next word, or it changes flow. A flow change loads a branch or call target, a return address from the stack, a fixed interrupt vector, or a new low byte written by software. A taken conditional skip also counts as a flow change. Because fetch and execute overlap, the word already fetched on any flow change is useless. The block then raises a flush flag for the next whole instruction cycle, and the decoder executes that word as a no-op. Calls and interrupt entry present the address of the discarded word on a stack push port, so execution can resume there later.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the block loads `fetch_addr` = 000H, `phase` = 0 (T1), `flush` = 0 and `push_en` = 0.
- R2: `phase` counts 0,1,2,3,0 (T1..T4), advancing only on clocks with `cyc_en` high. `fetch_addr` changes only on the enabled clock where `phase` is 3 (the instruction boundary).
- R3: On a boundary with no accepted request, `fetch_addr` increases by one and `flush` is 0. 3FFH is followed by 000H.
- R4: An accepted branch (`br_req` with `br_call` low) loads `br_target` and sets `flush` for one instruction cycle.
- R5: An accepted call (`br_req` with `br_call` high) loads `br_target`, sets `flush`, and pulses `push_en` for one clock. During that pulse `push_addr` holds the `fetch_addr` value from before the boundary.
- R6: An accepted return (`ret_req`) loads `ret_addr` and sets `flush`.
- R7: An accepted low-byte write (`pcl_wr`) replaces `fetch_addr[7:0]` with `pcl_data` and keeps bits 9:8, so the target stays in the current 256-word page. It sets `flush`.
- R8: An accepted taken skip (`skip_req`) advances `fetch_addr` by one, like a sequential step, and sets `flush`.
- R9: An accepted interrupt (`irq_req`) loads the vector (parameter default 004H), sets `flush`, and pulses `push_en` with `push_addr` equal to the `fetch_addr` value from before the boundary.
- R10: When several requests are high at one boundary, exactly one wins, in this order: interrupt, branch/call, return, low-byte write, skip.
- R11: Requests at the boundary that ends a flush cycle are ignored. The address steps by one, `flush` returns to 0 and `push_en` stays 0.
- R12: `flush` stays high for exactly one instruction cycle after a flow change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Phase advance enable |
| br_req | input | 1 | Branch or call request |
| br_call | input | 1 | Branch request is a call (push return address) |
| br_target | input | 10 | Branch or call target address |
| ret_req | input | 1 | Return request |
| ret_addr | input | 10 | Return address from the stack |
| irq_req | input | 1 | Interrupt entry request |
| pcl_wr | input | 1 | Software write of the low address byte |
| pcl_data | input | 8 | Low address byte write data |
| skip_req | input | 1 | Conditional skip taken |
| fetch_addr | output | 10 | Current fetch address |
| phase | output | 2 | Current phase, 0..3 for T1..T4 |
| flush | output | 1 | Executed word in this cycle is a dummy |
| push_en | output | 1 | One-clock stack push strobe |
| push_addr | output | 10 | Address to push |

## Verification
The bench first runs plain sequential steps, including the 3FFH to 000H wrap, to confirm the increment path alone. Directed single requests of each kind follow, which separate the loaded value of each kind: branch target, call target with a push, return address, paged low-byte write and skip step. Directed combinations then show the priority chain, and requests placed inside a flush cycle show that a dummy cycle accepts nothing. A long random mix of overlapping requests, with random gaps in `cyc_en`, checks that the phase count and the boundary-only address updates stay correct for any mix of requests.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [1:0] {
    PH_T1 = 2'd0,
    PH_T2 = 2'd1,
    PH_T3 = 2'd2,
    PH_T4 = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    FL_SEQ  = 3'd0,
    FL_SKIP = 3'd1,
    FL_PCL  = 3'd2,
    FL_RET  = 3'd3,
    FL_BR   = 3'd4,
    FL_IRQ  = 3'd5
  } flow_e;

endpackage

// File: rtl/pcs_phase_gen.sv
module pcs_phase_gen
  import pcs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   cyc_en,
  output phase_e phase_q,
  output logic   boundary
);

  // the T4 -> T1 hand-over, where the next fetch begins
  assign boundary = cyc_en && (phase_q == PH_T4);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_T1;
    end else if (cyc_en) begin
      phase_q <= phase_e'(phase_q + 2'd1);
    end
  end

  assert_phase_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !cyc_en |=> $stable(phase_q));

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
    (cyc_en && phase_q == PH_T2) |=> (phase_q == PH_T3));

endmodule

// File: rtl/pcs_next_sel.sv
module pcs_next_sel
  import pcs_pkg::*;
#(
  parameter int                ADDR_W   = 10,
  parameter int                LOW_W    = 8,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 'h004
) (
  input  logic [ADDR_W-1:0] pc_q,
  input  logic              flush_q,
  input  logic              irq_req,
  input  logic              br_req,
  input  logic              br_call,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              ret_req,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic              pcl_wr,
  input  logic [LOW_W-1:0]  pcl_data,
  input  logic              skip_req,
  output logic [ADDR_W-1:0] nxt_pc,
  output logic              nxt_flush,
  output logic              nxt_push
);

  localparam int HI_W = ADDR_W - LOW_W;

  flow_e             kind;
  logic [ADDR_W-1:0] inc_pc;
  logic [HI_W-1:0]   page;

  assign inc_pc = pc_q + ADDR_W'(1);
  assign page   = pc_q[ADDR_W-1:LOW_W];

  // priority chain; a dummy cycle accepts nothing
  always_comb begin
    kind   = FL_SEQ;
    nxt_pc = inc_pc;
    if (!flush_q) begin
      if (irq_req) begin
        kind   = FL_IRQ;
        nxt_pc = VEC_ADDR;
      end else if (br_req) begin
        kind   = FL_BR;
        nxt_pc = br_target;
      end else if (ret_req) begin
        kind   = FL_RET;
        nxt_pc = ret_addr;
      end else if (pcl_wr) begin
        kind   = FL_PCL;
        nxt_pc = {page, pcl_data};
      end else if (skip_req) begin
        kind   = FL_SKIP;
        nxt_pc = inc_pc;
      end
    end
  end

  assign nxt_flush = (kind != FL_SEQ);
  assign nxt_push  = (kind == FL_IRQ) || ((kind == FL_BR) && br_call);

endmodule

// File: rtl/pcs_addr_reg.sv
module pcs_addr_reg #(
  parameter int                ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] RST_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary,
  input  logic [ADDR_W-1:0] nxt_pc,
  input  logic              nxt_flush,
  input  logic              nxt_push,
  output logic [ADDR_W-1:0] pc_q,
  output logic              flush_q,
  output logic              push_en_q,
  output logic [ADDR_W-1:0] push_addr_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q        <= RST_ADDR;
      flush_q     <= 1'b0;
      push_en_q   <= 1'b0;
      push_addr_q <= '0;
    end else begin
      push_en_q <= 1'b0;
      if (boundary) begin
        pc_q    <= nxt_pc;
        flush_q <= nxt_flush;
        if (nxt_push) begin
          push_en_q   <= 1'b1;
          push_addr_q <= pc_q;
        end
      end
    end
  end

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> ($stable(pc_q) && $stable(flush_q)));

  assert_flush_single_R12: assert property (@(posedge clk) disable iff (rst)
    (boundary && flush_q) |=> !flush_q);

  assert_push_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    push_en_q |=> !push_en_q);

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int                ADDR_W   = 10,
  parameter int                LOW_W    = 8,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 'h004,
  parameter logic [ADDR_W-1:0] RST_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_en,
  input  logic              br_req,
  input  logic              br_call,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              ret_req,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic              irq_req,
  input  logic              pcl_wr,
  input  logic [LOW_W-1:0]  pcl_data,
  input  logic              skip_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [1:0]        phase,
  output logic              flush,
  output logic              push_en,
  output logic [ADDR_W-1:0] push_addr
);

  phase_e            phase_q;
  logic              boundary;
  logic [ADDR_W-1:0] nxt_pc;
  logic              nxt_flush;
  logic              nxt_push;

  pcs_phase_gen u_phase (
    .clk      (clk),
    .rst      (rst),
    .cyc_en   (cyc_en),
    .phase_q  (phase_q),
    .boundary (boundary)
  );

  pcs_next_sel #(
    .ADDR_W   (ADDR_W),
    .LOW_W    (LOW_W),
    .VEC_ADDR (VEC_ADDR)
  ) u_sel (
    .pc_q      (fetch_addr),
    .flush_q   (flush),
    .irq_req   (irq_req),
    .br_req    (br_req),
    .br_call   (br_call),
    .br_target (br_target),
    .ret_req   (ret_req),
    .ret_addr  (ret_addr),
    .pcl_wr    (pcl_wr),
    .pcl_data  (pcl_data),
    .skip_req  (skip_req),
    .nxt_pc    (nxt_pc),
    .nxt_flush (nxt_flush),
    .nxt_push  (nxt_push)
  );

  pcs_addr_reg #(
    .ADDR_W   (ADDR_W),
    .RST_ADDR (RST_ADDR)
  ) u_reg (
    .clk         (clk),
    .rst         (rst),
    .boundary    (boundary),
    .nxt_pc      (nxt_pc),
    .nxt_flush   (nxt_flush),
    .nxt_push    (nxt_push),
    .pc_q        (fetch_addr),
    .flush_q     (flush),
    .push_en_q   (push_en),
    .push_addr_q (push_addr)
  );

  assign phase = phase_q;

  assert_seq_inc_R3: assert property (@(posedge clk) disable iff (rst)
    (boundary && !flush && !irq_req && !br_req && !ret_req && !pcl_wr && !skip_req)
    |=> (fetch_addr == $past(fetch_addr) + ADDR_W'(1)) && !flush);

  assert_irq_vector_R9: assert property (@(posedge clk) disable iff (rst)
    (boundary && !flush && irq_req) |=> (fetch_addr == VEC_ADDR) && flush && push_en);

  assert_page_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (boundary && !flush && pcl_wr && !irq_req && !br_req && !ret_req)
    |=> (fetch_addr[ADDR_W-1:LOW_W] == $past(fetch_addr[ADDR_W-1:LOW_W]))
        && (fetch_addr[LOW_W-1:0] == $past(pcl_data)));

  assert_dummy_ignores_R11: assert property (@(posedge clk) disable iff (rst)
    (boundary && flush) |=> !push_en && (fetch_addr == $past(fetch_addr) + ADDR_W'(1)));

endmodule

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;

  localparam int AW = 10;
  localparam int LW = 8;
  localparam logic [AW-1:0] VEC = 10'h004;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cyc_en = 1'b0;
  logic          br_req = 1'b0, br_call = 1'b0, ret_req = 1'b0;
  logic          irq_req = 1'b0, pcl_wr = 1'b0, skip_req = 1'b0;
  logic [AW-1:0] br_target = '0, ret_addr = '0;
  logic [LW-1:0] pcl_data = '0;
  logic [AW-1:0] fetch_addr, push_addr;
  logic [1:0]    phase;
  logic          flush, push_en;

  pc_sequencer i_pc_sequencer (
    .clk(clk), .rst(rst), .cyc_en(cyc_en),
    .br_req(br_req), .br_call(br_call), .br_target(br_target),
    .ret_req(ret_req), .ret_addr(ret_addr), .irq_req(irq_req),
    .pcl_wr(pcl_wr), .pcl_data(pcl_data), .skip_req(skip_req),
    .fetch_addr(fetch_addr), .phase(phase), .flush(flush),
    .push_en(push_en), .push_addr(push_addr)
  );

  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  logic [AW-1:0] m_pc = '0;
  logic          m_flush = 1'b0;
  int            m_phase = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  task automatic set_req(input logic irq, input logic br, input logic call,
                         input logic [AW-1:0] tgt, input logic ret,
                         input logic [AW-1:0] ra, input logic wr,
                         input logic [LW-1:0] wd, input logic skp);
    irq_req = irq; br_req = br; br_call = call; br_target = tgt;
    ret_req = ret; ret_addr = ra; pcl_wr = wr; pcl_data = wd; skip_req = skp;
  endtask

  // expected result of one boundary, derived from the requirements
  task automatic model_step(output logic [AW-1:0] npc, output logic nfl,
                            output logic npush, output string tag);
    int nreq;
    nreq = int'(irq_req) + int'(br_req) + int'(ret_req) + int'(pcl_wr) + int'(skip_req);
    npc = m_pc + 10'd1; nfl = 1'b0; npush = 1'b0;
    if (m_flush) tag = (nreq != 0) ? "R11" : "R12";
    else if (irq_req) begin npc = VEC; nfl = 1'b1; npush = 1'b1; tag = "R9"; end
    else if (br_req) begin npc = br_target; nfl = 1'b1; npush = br_call; tag = br_call ? "R5" : "R4"; end
    else if (ret_req) begin npc = ret_addr; nfl = 1'b1; tag = "R6"; end
    else if (pcl_wr) begin npc = {m_pc[AW-1:LW], pcl_data}; nfl = 1'b1; tag = "R7"; end
    else if (skip_req) begin nfl = 1'b1; tag = "R8"; end
    else tag = "R3";
    if (!m_flush && nreq > 1) tag = "R10";
  endtask

  // one instruction cycle with random enable gaps; requests held throughout
  task automatic run_icycle();
    logic          done;
    logic [AW-1:0] npc, old_pc;
    logic          nfl, npush;
    string         tag;
    done = 1'b0;
    while (!done) begin
      cyc_en = ($urandom % 4) != 0;
      check("R2 phase", 32'(phase), 32'(m_phase));
      check("R2 addr", 32'(fetch_addr), 32'(m_pc));
      model_step(npc, nfl, npush, tag);
      old_pc = m_pc;
      @(posedge clk);
      if (cyc_en) begin
        if (m_phase == 3) done = 1'b1;
        m_phase = (m_phase + 1) % 4;
      end
      @(negedge clk);
      if (done) begin
        m_pc = npc; m_flush = nfl;
        check({tag, " addr"}, 32'(fetch_addr), 32'(npc));
        check({tag, " flush"}, 32'(flush), 32'(nfl));
        check({tag, " push_en"}, 32'(push_en), 32'(npush));
        if (npush) check({tag, " push_addr"}, 32'(push_addr), 32'(old_pc));
        set_req(0, 0, 0, '0, 0, '0, 0, '0, 0);
      end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) begin
      cyc_en = $urandom % 2;
      @(posedge clk);
    end
    @(negedge clk);
    rst = 1'b0;
    m_pc = '0; m_flush = 1'b0; m_phase = 0;
    check("R1 addr", 32'(fetch_addr), 32'h0);
    check("R1 phase", 32'(phase), 32'h0);
    check("R1 flush", 32'(flush), 32'h0);
    check("R1 push_en", 32'(push_en), 32'h0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R3 sequential steps
    repeat (3) run_icycle();
    // R4 branch near top, then R3 wrap through 3FF
    set_req(0, 1, 0, 10'h3FE, 0, '0, 0, '0, 0); run_icycle();
    run_icycle();
    run_icycle();
    run_icycle();
    // R7 paged write
    set_req(0, 1, 0, 10'h2A5, 0, '0, 0, '0, 0); run_icycle();
    run_icycle();
    set_req(0, 0, 0, '0, 0, '0, 1, 8'h10, 0); run_icycle();
    run_icycle();
    // R8 skip
    set_req(0, 0, 0, '0, 0, '0, 0, '0, 1); run_icycle();
    run_icycle();
    // R5 call
    set_req(0, 1, 1, 10'h155, 0, '0, 0, '0, 0); run_icycle();
    run_icycle();
    // R6 return
    set_req(0, 0, 0, '0, 1, 10'h0C3, 0, '0, 0); run_icycle();
    run_icycle();
    // R9 interrupt
    set_req(1, 0, 0, '0, 0, '0, 0, '0, 0); run_icycle();
    // R11 request during dummy cycle
    set_req(0, 1, 1, 10'h300, 1, 10'h111, 1, 8'h77, 1); run_icycle();
    // R10 priority chains
    set_req(1, 1, 1, 10'h300, 1, 10'h111, 1, 8'h77, 1); run_icycle();
    run_icycle();
    set_req(0, 1, 0, 10'h300, 1, 10'h111, 1, 8'h77, 1); run_icycle();
    run_icycle();
    set_req(0, 0, 0, '0, 1, 10'h111, 1, 8'h77, 1); run_icycle();
    run_icycle();
    set_req(0, 0, 0, '0, 0, '0, 1, 8'h77, 1); run_icycle();
    run_icycle();
    // random mix
    for (int i = 0; i < 400; i++) begin
      set_req(($urandom % 10) == 0, ($urandom % 6) == 0, $urandom % 2,
              AW'($urandom), ($urandom % 6) == 0, AW'($urandom),
              ($urandom % 6) == 0, LW'($urandom), ($urandom % 5) == 0);
      run_icycle();
      if (i == 200) do_reset();
    end
    finish_run();
  end

endmodule